// File: doc/BRIEF.md
# Tagged Receive Silo for a Sixteen-Line Serial Multiplexer

This block is the receive buffer shared by sixteen serial lines. Each line's receiver hands over a finished character through a simple push interface together with its line number and its parity and framing error indications. Every accepted character goes into one common FIFO. The stored word carries the line number, the error flags and an overrun mark, so a single receive-character register is enough to tell where every character came from.

Software drains the silo by reading the receive-character register until bit 15 reads clear. Each read returns the entry at the head and removes it. A control-status register holds the receive and storage interrupt enables and flags, a master-clear command and a maintenance loopback select. An alarm register sets how full the silo must be before the receive flag rises. This lets software take one interrupt for a batch of characters instead of one per character.

Top module: `mux_rx_silo`

## Requirements
- R1: A read of the receive-character register (select 1) while the silo holds data returns bit 15 = 1, bits 11:8 = line, bits 7:0 = character, bit 12 = parity error, bit 13 = framing error, bit 14 = overrun. The same read removes that entry.
- R2: A read of the receive-character register while the silo is empty returns 16'h0000 and leaves the occupancy unchanged.
- R3: Entries leave in the order they arrived, and each receive-character read removes exactly one entry.
- R4: Suppose a character arrives while the occupancy equals DEPTH, even with a read in the same cycle. That character is discarded and the storage flag (control bit 14) is set. The next entry stored for that same line, and for no other line, carries the overrun bit 14.
- R5: The receive flag (control bit 7) is set when a stored character brings the occupancy to at least the alarm level. With an alarm level of 0, every stored character sets it.
- R6: A control write clears a flag only when it writes 0 to that flag's bit. Writing 1 leaves the flag as it is. A set event in the same cycle wins over the clear.
- R7: irq equals (receive flag AND bit 6 enable) OR (storage flag AND bit 12 enable).
- R8: A control write with bit 11 = 1 empties the silo. It also clears both flags, both enables, the maintenance bit, the alarm level and all pending overrun marks. A character arriving in that cycle is discarded. Bit 11 always reads 0.
- R9: With control bit 9 = 1, characters come from the loopback inputs with both error flags 0, and the external receive inputs are ignored. With bit 9 = 0, the loopback inputs are ignored.
- R10: The alarm register (select 2) takes the alarm level in bits 6:0 on a write. On a read it returns that level in bits 6:0 and the current occupancy in bits 14:8.
- R11: After reset, the control, receive-character and alarm registers read 0 and irq is 0.
- R12: A push or register write at a rising edge is visible on reg_rdata and irq right after that edge. Read data is present before the edge that removes the entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | External receiver presents a character this cycle |
| rx_line | input | 4 | Line number of the external character |
| rx_char | input | 8 | External character |
| rx_perr | input | 1 | Parity error on the external character |
| rx_ferr | input | 1 | Framing error (break) on the external character |
| lb_valid | input | 1 | Loopback path presents a character this cycle |
| lb_line | input | 4 | Line number of the loopback character |
| lb_char | input | 8 | Loopback character |
| reg_sel | input | 2 | Register select: 0 control, 1 receive character, 2 alarm |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes an entry when select is 1) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from state |
| irq | output | 1 | Interrupt request |

## Verification
A push, a register write, a master clear or a reset takes effect at one rising edge. Its result shows on reg_rdata and irq one register stage later, right after that edge, because both outputs are decoded combinationally from flops. The bench therefore changes stimulus at the falling edge. It checks flags, occupancy and irq 1 ns after the following rising edge. For a receive-character read it samples reg_rdata 5 ns after the falling edge, while the read strobe is held and before the rising edge that removes the entry. This keeps each check on the cycle where the requirement says the value is due.

// File: rtl/rxs_pkg.sv
// Shared definitions for the tagged receive silo.
// Assumes: entry format fixed at 4 line bits and 8 character bits.
package rxs_pkg;
    localparam int LINE_W    = 4;
    localparam int CHAR_W    = 8;
    localparam int NUM_LINES = 1 << LINE_W;
    localparam int REG_W     = 16;

    // Control-register bit positions (software decodes these)
    localparam int CSR_RIE   = 6;
    localparam int CSR_RI    = 7;
    localparam int CSR_MAINT = 9;
    localparam int CSR_MCLR  = 11;
    localparam int CSR_SIE   = 12;
    localparam int CSR_SI    = 14;

    // Alarm register: occupancy field starts here
    localparam int OCC_LSB   = 8;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] data;
    } silo_entry_t;

    typedef enum logic [1:0] {
        SEL_CSR   = 2'd0,
        SEL_RCR   = 2'd1,
        SEL_ALARM = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/rxs_src_mux.sv
// Chooses the character source for the silo: the external receivers
// in normal mode, the loopback path in maintenance mode.
// Assumes: loopback characters never carry parity or framing errors.
module rxs_src_mux
    import rxs_pkg::*;
(
    input  logic              maint,
    input  logic              rx_valid,
    input  logic [LINE_W-1:0] rx_line,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              lb_valid,
    input  logic [LINE_W-1:0] lb_line,
    input  logic [CHAR_W-1:0] lb_char,
    output logic              src_valid,
    output silo_entry_t       src_entry
);
    // Select the active source and clear flags not produced by it
    always_comb begin
        src_entry     = '0;
        if (maint) begin
            src_valid      = lb_valid;
            src_entry.line = lb_line;
            src_entry.data = lb_char;
        end else begin
            src_valid      = rx_valid;
            src_entry.line = rx_line;
            src_entry.data = rx_char;
            src_entry.perr = rx_perr;
            src_entry.ferr = rx_ferr;
        end
    end
endmodule

// File: rtl/rxs_fifo.sv
// Storage for silo entries with occupancy count.
// Assumes: DEPTH is a power of two between 2 and 64; the caller never
// writes when full nor reads when empty; clr acts as a synchronous flush.
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr_en,
    input  silo_entry_t wr_entry,
    input  logic        rd_en,
    output silo_entry_t head,
    output logic [$clog2(DEPTH+1)-1:0] occ,
    output logic        empty,
    output logic        full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    silo_entry_t   mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    // Write the incoming entry at the tail
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_entry;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (wr_en) wptr <= wptr + AW'(1);
            if (rd_en) rptr <= rptr + AW'(1);
            occ <= occ + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign head  = mem[rptr];
    assign empty = (occ == '0);
    assign full  = (occ == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (occ < CW'(DEPTH)));  // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (occ != '0));  // R2
    AST_OCC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (occ == CW'($past(occ) + CW'($past(wr_en)) - CW'($past(rd_en)))));  // R3
endmodule

// File: rtl/rxs_ovr_track.sv
// Remembers, per line, that a character was lost to a full silo, and
// supplies the overrun mark for the next entry stored for that line.
// Assumes: store and drop are never both high in one cycle.
module rxs_ovr_track
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              store,
    input  logic              drop,
    input  logic [LINE_W-1:0] line,
    output logic              ovr_tag
);
    logic [NUM_LINES-1:0] pend;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic pend_q;
        logic hit;
        assign hit = (line == LINE_W'(g));
        // Arm on a drop for this line, disarm when its next entry is stored
        always_ff @(posedge clk) begin
            if (!rst_n || clr)     pend_q <= 1'b0;
            else if (drop && hit)  pend_q <= 1'b1;
            else if (store && hit) pend_q <= 1'b0;
        end
        assign pend[g] = pend_q;
    end

    assign ovr_tag = pend[line];

    AST_OVR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clr) |=> pend[$past(line)]);  // R4
    AST_OVR_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> !pend[$past(line)]);  // R4
endmodule

// File: rtl/rxs_regs.sv
// Register port: control flags, alarm level, read decode and irq.
// Assumes: DEPTH <= 64 so the occupancy fits bits 14:8 of the alarm
// register; store and drop are already gated off during master clear.
module rxs_regs
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             store,
    input  logic             drop,
    input  logic [$clog2(DEPTH+1)-1:0] occ,
    input  logic             empty,
    input  silo_entry_t      head,
    output logic [REG_W-1:0] reg_rdata,
    output logic             maint,
    output logic             mclr,
    output logic             pop,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic          rie, ri, sie, si;
    logic [CW-1:0] alarm;
    logic          csr_wr, alarm_wr;
    logic [CW:0]   occ_new;
    logic          ri_set;
    logic [REG_W-1:0] csr_val, alarm_val, rcr_val;
    logic          unused_wbits;

    assign csr_wr   = reg_wr && (reg_sel == SEL_CSR);
    assign alarm_wr = reg_wr && (reg_sel == SEL_ALARM);
    assign mclr     = csr_wr && reg_wdata[CSR_MCLR];
    assign pop      = reg_rd && (reg_sel == SEL_RCR) && !empty;

    // Occupancy after this cycle, compared to the alarm level
    assign occ_new = {1'b0, occ} + (CW+1)'(1) - (CW+1)'(pop);
    assign ri_set  = store && (occ_new >= {1'b0, alarm});

    // Control flags and enables; set events win over software clears
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            rie   <= 1'b0;
            sie   <= 1'b0;
            ri    <= 1'b0;
            si    <= 1'b0;
            maint <= 1'b0;
        end else if (csr_wr) begin
            rie   <= reg_wdata[CSR_RIE];
            sie   <= reg_wdata[CSR_SIE];
            maint <= reg_wdata[CSR_MAINT];
            ri    <= (ri & reg_wdata[CSR_RI]) | ri_set;
            si    <= (si & reg_wdata[CSR_SI]) | drop;
        end else begin
            ri    <= ri | ri_set;
            si    <= si | drop;
        end
    end

    // Alarm level register
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) alarm <= '0;
        else if (alarm_wr)  alarm <= reg_wdata[CW-1:0];
    end

    // Assemble the readable images of each register
    always_comb begin
        csr_val            = '0;
        csr_val[CSR_RIE]   = rie;
        csr_val[CSR_RI]    = ri;
        csr_val[CSR_MAINT] = maint;
        csr_val[CSR_SIE]   = sie;
        csr_val[CSR_SI]    = si;
        alarm_val                  = '0;
        alarm_val[CW-1:0]          = alarm;
        alarm_val[OCC_LSB +: CW]   = occ;
        rcr_val = empty ? '0 : {1'b1, head.ovr, head.ferr, head.perr, head.line, head.data};
    end

    // Read mux
    always_comb begin
        case (reg_sel)
            SEL_CSR:   reg_rdata = csr_val;
            SEL_RCR:   reg_rdata = rcr_val;
            SEL_ALARM: reg_rdata = alarm_val;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = (ri & rie) | (si & sie);
    assign unused_wbits = ^{reg_wdata[15], reg_wdata[13], reg_wdata[10], reg_wdata[8]};

    AST_RI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !csr_wr) |=> ri);  // R6
    AST_RI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !reg_wdata[CSR_RI] && !store) |=> !ri);  // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rie || sie));  // R7
    AST_MCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (occ == '0));  // R8
endmodule

// File: rtl/mux_rx_silo.sv
// Top of the tagged receive silo: one FIFO shared by sixteen lines,
// each entry tagged with line number and error flags.
// Assumes: DEPTH is a power of two from 2 to 64.
module mux_rx_silo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [3:0]  rx_line,
    input  logic [7:0]  rx_char,
    input  logic        rx_perr,
    input  logic        rx_ferr,
    input  logic        lb_valid,
    input  logic [3:0]  lb_line,
    input  logic [7:0]  lb_char,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic          maint, mclr, pop;
    logic          src_valid, store, drop, ovr_tag;
    logic          empty, full;
    logic [CW-1:0] occ;
    silo_entry_t   src_entry, wr_entry, head;

    rxs_src_mux u_src (
        .maint     (maint),
        .rx_valid  (rx_valid),
        .rx_line   (rx_line),
        .rx_char   (rx_char),
        .rx_perr   (rx_perr),
        .rx_ferr   (rx_ferr),
        .lb_valid  (lb_valid),
        .lb_line   (lb_line),
        .lb_char   (lb_char),
        .src_valid (src_valid),
        .src_entry (src_entry)
    );

    // Accept when room exists; otherwise count it as a lost character
    assign store = src_valid && !full && !mclr;
    assign drop  = src_valid &&  full && !mclr;

    rxs_ovr_track u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mclr),
        .store   (store),
        .drop    (drop),
        .line    (src_entry.line),
        .ovr_tag (ovr_tag)
    );

    // Attach the pending overrun mark to the entry being stored
    always_comb begin
        wr_entry     = src_entry;
        wr_entry.ovr = ovr_tag;
    end

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mclr),
        .wr_en    (store),
        .wr_entry (wr_entry),
        .rd_en    (pop),
        .head     (head),
        .occ      (occ),
        .empty    (empty),
        .full     (full)
    );

    rxs_regs #(.DEPTH(DEPTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .store     (store),
        .drop      (drop),
        .occ       (occ),
        .empty     (empty),
        .head      (head),
        .reg_rdata (reg_rdata),
        .maint     (maint),
        .mclr      (mclr),
        .pop       (pop),
        .irq       (irq)
    );

    AST_LOOP_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
        (maint && !lb_valid) |-> !store);  // R9
    AST_EXT_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!maint && !rx_valid) |-> !store);  // R9
endmodule

// File: tb/mux_rx_silo_bench.sv
`timescale 1ns/1ps
module mux_rx_silo_bench;
    localparam int DEPTH = 64;
    localparam int WDOG  = 150000;
    localparam logic [1:0] OP_RX = 2'd0, OP_LB = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;
    localparam logic [1:0] S_CSR = 2'd0, S_RCR = 2'd1, S_ALR = 2'd2;
    localparam int NVEC = 38;

    // {op, sel, data, expected, requirement number}
    localparam logic [39:0] VEC [NVEC] = '{
        {OP_RD, S_CSR, 16'h0000, 16'h0000, 4'd11},  // R11 reset control
        {OP_RD, S_RCR, 16'h0000, 16'h0000, 4'd2},   // R2 empty read
        {OP_RD, S_ALR, 16'h0000, 16'h0000, 4'd11},  // R11 reset alarm
        {OP_WR, S_CSR, 16'h0040, 16'h0000, 4'd0},
        {OP_RX, S_CSR, 16'h1341, 16'h0000, 4'd0},
        {OP_RX, S_CSR, 16'h2A7E, 16'h0000, 4'd0},
        {OP_RD, S_CSR, 16'h0000, 16'h00C0, 4'd5},   // R5 alarm 0
        {OP_RD, S_ALR, 16'h0000, 16'h0200, 4'd10},  // R10 occupancy
        {OP_RD, S_RCR, 16'h0000, 16'h9341, 4'd1},   // R1 parity tag
        {OP_RD, S_RCR, 16'h0000, 16'hAA7E, 4'd1},   // R1 framing, R3 order
        {OP_RD, S_RCR, 16'h0000, 16'h0000, 4'd2},   // R2
        {OP_RD, S_ALR, 16'h0000, 16'h0000, 4'd10},  // R10
        {OP_WR, S_CSR, 16'h00C0, 16'h0000, 4'd0},
        {OP_RD, S_CSR, 16'h0000, 16'h00C0, 4'd6},   // R6 write 1 keeps
        {OP_WR, S_CSR, 16'h0040, 16'h0000, 4'd0},
        {OP_RD, S_CSR, 16'h0000, 16'h0040, 4'd6},   // R6 write 0 clears
        {OP_WR, S_ALR, 16'h0003, 16'h0000, 4'd0},
        {OP_RX, S_CSR, 16'h0161, 16'h0000, 4'd0},
        {OP_RX, S_CSR, 16'h0262, 16'h0000, 4'd0},
        {OP_RD, S_CSR, 16'h0000, 16'h0040, 4'd5},   // R5 below alarm
        {OP_RX, S_CSR, 16'h0063, 16'h0000, 4'd0},
        {OP_RD, S_CSR, 16'h0000, 16'h00C0, 4'd5},   // R5 at alarm
        {OP_WR, S_CSR, 16'h0240, 16'h0000, 4'd0},
        {OP_RD, S_CSR, 16'h0000, 16'h0240, 4'd9},   // R9 maint bit
        {OP_RX, S_CSR, 16'h0555, 16'h0000, 4'd0},
        {OP_LB, S_CSR, 16'h0F33, 16'h0000, 4'd0},
        {OP_RD, S_ALR, 16'h0000, 16'h0403, 4'd9},   // R9 only loopback stored
        {OP_RD, S_CSR, 16'h0000, 16'h02C0, 4'd5},   // R5
        {OP_RD, S_RCR, 16'h0000, 16'h8161, 4'd3},   // R3
        {OP_RD, S_RCR, 16'h0000, 16'h8262, 4'd3},   // R3
        {OP_RD, S_RCR, 16'h0000, 16'h8063, 4'd3},   // R3
        {OP_RD, S_RCR, 16'h0000, 16'h8F33, 4'd9},   // R9 loopback entry
        {OP_RD, S_RCR, 16'h0000, 16'h0000, 4'd9},   // R9 rx ignored
        {OP_WR, S_CSR, 16'h0800, 16'h0000, 4'd0},
        {OP_RD, S_CSR, 16'h0000, 16'h0000, 4'd8},   // R8
        {OP_RD, S_ALR, 16'h0000, 16'h0000, 4'd8},   // R8
        {OP_LB, S_CSR, 16'h0F44, 16'h0000, 4'd0},
        {OP_RD, S_RCR, 16'h0000, 16'h0000, 4'd9}    // R9 loopback ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, lb_valid = 1'b0;
    logic [3:0]  rx_line = '0, lb_line = '0;
    logic [7:0]  rx_char = '0, lb_char = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    mux_rx_silo #(.DEPTH(DEPTH)) u_mux_rx_silo (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_line(rx_line), .rx_char(rx_char),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .lb_valid(lb_valid), .lb_line(lb_line), .lb_char(lb_char),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check16(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        rx_valid = 1'b0; lb_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [15:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_line = d[11:8]; rx_char = d[7:0];
        rx_perr = d[12]; rx_ferr = d[13];
        step();
    endtask

    task automatic push_lb(input logic [15:0] d);
        @(negedge clk);
        lb_valid = 1'b1; lb_line = d[11:8]; lb_char = d[7:0];
        step();
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
        step();
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [15:0] e, input string tag);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #5;
        check16(tag, reg_rdata, e);
        step();
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog got %0d cycles exp fewer", WDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check16("R11 irq after reset", {15'b0, irq}, 16'h0000);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] v;
            v = VEC[i];
            case (v[39:38])
                OP_RX:   push_rx(v[35:20]);
                OP_LB:   push_lb(v[35:20]);
                OP_WR:   wr_reg(v[37:36], v[35:20]);
                default: rd_chk(v[37:36], v[19:4], $sformatf("R%0d vec%0d", v[3:0], i));
            endcase
        end

        // R7 irq gating, R6 flag kept while enables change
        wr_reg(S_CSR, 16'h0800);
        wr_reg(S_CSR, 16'h0040);
        push_rx(16'h0111);
        check16("R7 irq with RI and RIE", {15'b0, irq}, 16'h0001);
        wr_reg(S_CSR, 16'h0080);
        check16("R7 irq RIE off", {15'b0, irq}, 16'h0000);
        rd_chk(S_CSR, 16'h0080, "R6 RI kept by writing 1");
        wr_reg(S_CSR, 16'h1080);
        check16("R7 irq SIE on, SI clear", {15'b0, irq}, 16'h0000);

        // R4 overflow with per-line overrun tag
        wr_reg(S_CSR, 16'h0800);
        wr_reg(S_CSR, 16'h1000);
        for (int i = 0; i < DEPTH; i++) push_rx(16'h0200 | 16'(i));
        rd_chk(S_ALR, 16'h4000, "R4 silo full occupancy");
        push_rx(16'h0599);
        rd_chk(S_CSR, 16'h5080, "R4 storage flag on drop");
        check16("R7 irq from storage flag", {15'b0, irq}, 16'h0001);
        rd_chk(S_ALR, 16'h4000, "R4 dropped char not stored");
        rd_chk(S_RCR, 16'h8200, "R3 head after fill");
        rd_chk(S_RCR, 16'h8201, "R3 second entry");
        push_rx(16'h0711);
        push_rx(16'h0522);
        for (int i = 2; i < DEPTH; i++) rd_chk(S_RCR, 16'h8200 | 16'(i), "R3 drain order");
        rd_chk(S_RCR, 16'h8711, "R4 other line untagged");
        rd_chk(S_RCR, 16'hC522, "R4 overrun tag on dropping line");
        push_rx(16'h0523);
        rd_chk(S_RCR, 16'h8523, "R4 tag used once");

        // R8 master clear discards a same-cycle arrival
        push_rx(16'h0301);
        @(negedge clk);
        rx_valid = 1'b1; rx_line = 4'h4; rx_char = 8'h77; rx_perr = 1'b0; rx_ferr = 1'b0;
        reg_sel = S_CSR; reg_wr = 1'b1; reg_wdata = 16'h0800;
        step();
        rd_chk(S_RCR, 16'h0000, "R8 silo empty after clear");
        rd_chk(S_ALR, 16'h0000, "R8 occupancy zero");

        // R11 reset with content pending
        push_rx(16'h0312);
        wr_reg(S_CSR, 16'h1240);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check16("R11 irq after mid-run reset", {15'b0, irq}, 16'h0000);
        rd_chk(S_CSR, 16'h0000, "R11 control after reset");
        rd_chk(S_RCR, 16'h0000, "R11 silo after reset");
        rd_chk(S_ALR, 16'h0000, "R11 alarm after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule